// File: doc/BRIEF.md
# Triplicated Serialized Link Codec

This block is the transmit and receive pair for one point-to-point link between two neighbouring network switches. On the transmit side a parallel word passes through an optional bus-invert stage. That stage flips the word when flipping lowers the number of toggling wires against the previously sent word, and records the choice in a flag bit. The resulting payload is then copied three times. A 4:1 shift-register serializer splits the tripled word into four phits and drives them onto a link a quarter of the coded width, one phit per clock, with a frame strobe on the first phit.

On the receive side a shift register gathers four phits back into a coded word. A bitwise two-of-three vote corrects it, and the inversion is undone when the voted flag says so. The word is presented on a valid/ready port together with a flag telling whether any copy disagreed. There is no retransmission: the receiver repairs errors on its own. Both parallel ports move at most one word every four clocks, a quarter of the link shift rate.

The parameters must make three times the payload width (data bits plus the flag bit when inversion is on) a multiple of four. With the defaults the data is 15 bits, the payload 16 bits, the coded word 48 bits and each phit 12 bits.

Top module: `link_codec`

## Requirements
- R1: While reset is asserted and right after it, in_ready_o is 1, and link_valid_o, link_frame_o and out_valid_o are 0.
- R2: The payload is {flag, data} (flag at bit DATA_W). The coded word holds copy 0 in bits [PAY_W-1:0], copy 1 in [2*PAY_W-1:PAY_W] and copy 2 in [3*PAY_W-1:2*PAY_W]. Phit k is coded[k*PHIT_W +: PHIT_W] and phit 0 goes first. The phits appear on four consecutive cycles with link_valid_o high, starting the cycle after acceptance.
- R3: link_frame_o is high only in the cycle that carries phit 0 of a word.
- R4: in_ready_o is low from acceptance through the cycle carrying phit 2, and high again in the cycle carrying phit 3. A waiting word is therefore taken on the edge that ends phit 3, and its phit 0 follows at once, so a new word can start every four cycles.
- R5: With inversion enabled, the flag is 1 and the data field carries the complement of the input exactly when more than DATA_W/2 (integer division) bits differ from the data field of the previous sent payload (zero after reset). Otherwise the flag is 0 and the data is sent as is.
- R6: At the receiver, a valid phit with link_frame_i high starts a new word and discards any partial one. The fourth valid phit of the word completes it, and out_valid_o rises in the next cycle.
- R7: Each payload bit is the two-of-three majority of its copies. When the voted flag is 1, out_data_o is the complement of the voted data field.
- R8: out_corrected_o is 1 for a word exactly when, at some payload bit position, the three copies were not all equal.
- R9: out_valid_o and its word stay unchanged until out_ready_i is high. A newly completed word replaces one that has not been taken.
- R10: Cycles with link_valid_i low are ignored by the receiver: a partial word keeps its phits and resumes on the next valid phit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both sides and for the link |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Transmit word offered |
| in_ready_o | output | 1 | Transmitter can take a word |
| in_data_i | input | DATA_W | Transmit word |
| link_valid_o | output | 1 | Outgoing phit valid |
| link_frame_o | output | 1 | Outgoing phit is phit 0 of a word |
| link_data_o | output | PHIT_W | Outgoing phit |
| link_valid_i | input | 1 | Incoming phit valid |
| link_frame_i | input | 1 | Incoming phit is phit 0 of a word |
| link_data_i | input | PHIT_W | Incoming phit |
| out_valid_o | output | 1 | Received word available |
| out_ready_i | input | 1 | Sink takes the received word |
| out_data_o | output | DATA_W | Corrected received word |
| out_corrected_o | output | 1 | At least one copy disagreed in this word |

## Verification
A serializer phase counter that is off by one shows up within a word. The frame strobe moves, ready opens a cycle early or late, and the phits gathered from the link no longer match the computed copy layout. A wrong history register in the invert stage shows up in the flag bit of the very next word sent, and the words near the inversion threshold expose it. A receiver assembly counter that slips shows up on the next completed word, either as a shifted word or as a strobe that arrives too early. The raw-link tests, with partial frames and gaps, drive this path directly. A wrong vote or a missed disagreement shows in the cycle after phit 3, in out_data_o and out_corrected_o.

// File: rtl/link_codec_pkg.sv
package link_codec_pkg;

  localparam int unsigned SER_RATIO = 4;
  localparam int unsigned SER_CNT_W = $clog2(SER_RATIO);

  typedef enum logic {
    TX_IDLE,
    TX_SEND
  } tx_state_e;

  function automatic int unsigned pay_width(int unsigned data_w, bit inv_en);
    return data_w + (inv_en ? 1 : 0);
  endfunction

  function automatic int unsigned phit_width(int unsigned data_w, bit inv_en);
    return (3 * pay_width(data_w, inv_en)) / SER_RATIO;
  endfunction

endpackage

// File: rtl/lc_bus_coder.sv
module lc_bus_coder #(
  parameter int unsigned DATA_W = 15,
  parameter bit          INV_EN = 1'b1,
  localparam int unsigned PAY_W = DATA_W + (INV_EN ? 1 : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PAY_W-1:0]  payload_o
);

  generate
    if (INV_EN) begin : g_invert
      localparam int unsigned CNT_W = $clog2(DATA_W + 1);
      localparam logic [CNT_W-1:0] HALF = CNT_W'(DATA_W / 2);

      logic [DATA_W-1:0] prev_q;
      logic [DATA_W-1:0] diff;
      logic [CNT_W-1:0]  diff_cnt;
      logic              flip;

      assign diff = data_i ^ prev_q;

      always_comb begin
        diff_cnt = '0;
        for (int i = 0; i < DATA_W; i++) begin
          diff_cnt = diff_cnt + CNT_W'(diff[i]);
        end
      end

      assign flip      = diff_cnt > HALF;
      assign payload_o = {flip, flip ? ~data_i : data_i};

      // history of what the wires last carried, not of the raw input
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= '0;
        end else if (load_i) begin
          prev_q <= payload_o[DATA_W-1:0];
        end
      end
    end else begin : g_plain
      assign payload_o = data_i;
    end
  endgenerate

endmodule

// File: rtl/lc_serializer.sv
module lc_serializer
  import link_codec_pkg::*;
#(
  parameter int unsigned PHIT_W = 12,
  localparam int unsigned CODE_W = PHIT_W * SER_RATIO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [CODE_W-1:0] coded_i,
  output logic              link_valid_o,
  output logic              link_frame_o,
  output logic [PHIT_W-1:0] link_data_o
);

  localparam logic [SER_CNT_W-1:0] LAST = SER_CNT_W'(SER_RATIO - 1);

  tx_state_e             state_q;
  logic [SER_CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0]     sreg_q;
  logic                  last;
  logic                  load;

  assign last    = (state_q == TX_SEND) && (cnt_q == LAST);
  assign ready_o = (state_q == TX_IDLE) || last;
  assign load    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
    end else if (load) begin
      state_q <= TX_SEND;
      cnt_q   <= '0;
      sreg_q  <= coded_i;
    end else if (state_q == TX_SEND) begin
      cnt_q   <= cnt_q + 1'b1;
      sreg_q  <= {{PHIT_W{1'b0}}, sreg_q[CODE_W-1:PHIT_W]};
      if (last) state_q <= TX_IDLE;
    end
  end

  assign link_valid_o = (state_q == TX_SEND);
  assign link_frame_o = (state_q == TX_SEND) && (cnt_q == '0);
  assign link_data_o  = sreg_q[PHIT_W-1:0];

endmodule

// File: rtl/lc_deserializer.sv
module lc_deserializer
  import link_codec_pkg::*;
#(
  parameter int unsigned PHIT_W = 12,
  localparam int unsigned CODE_W = PHIT_W * SER_RATIO,
  localparam int unsigned HOLD_W = CODE_W - PHIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_valid_i,
  input  logic              link_frame_i,
  input  logic [PHIT_W-1:0] link_data_i,
  output logic              done_o,
  output logic [CODE_W-1:0] word_o
);

  localparam logic [SER_CNT_W-1:0] LAST = SER_CNT_W'(SER_RATIO - 1);

  // cnt_q = phits held for the word in progress, 0 = none
  logic [SER_CNT_W-1:0] cnt_q;
  logic [HOLD_W-1:0]    sreg_q;
  logic [HOLD_W-1:0]    sreg_shift;

  assign sreg_shift = {link_data_i, sreg_q[HOLD_W-1:PHIT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else if (link_valid_i) begin
      if (link_frame_i) begin
        sreg_q <= sreg_shift;
        cnt_q  <= SER_CNT_W'(1);
      end else if (cnt_q != '0) begin
        sreg_q <= sreg_shift;
        cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign done_o = link_valid_i && !link_frame_i && (cnt_q == LAST);
  assign word_o = {link_data_i, sreg_q};

endmodule

// File: rtl/lc_vote_decoder.sv
module lc_vote_decoder #(
  parameter int unsigned DATA_W = 15,
  parameter bit          INV_EN = 1'b1,
  localparam int unsigned PAY_W  = DATA_W + (INV_EN ? 1 : 0),
  localparam int unsigned TRIP_W = 3 * PAY_W
) (
  input  logic [TRIP_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corrected_o
);

  logic [PAY_W-1:0] voted;
  logic [PAY_W-1:0] split;

  for (genvar b = 0; b < PAY_W; b++) begin : g_vote
    logic c0, c1, c2;
    assign c0 = word_i[b];
    assign c1 = word_i[PAY_W + b];
    assign c2 = word_i[2*PAY_W + b];
    assign voted[b] = (c0 & c1) | (c0 & c2) | (c1 & c2);
    assign split[b] = (c0 ^ c1) | (c1 ^ c2);
  end

  assign corrected_o = |split;

  generate
    if (INV_EN) begin : g_uninvert
      assign data_o = voted[DATA_W] ? ~voted[DATA_W-1:0] : voted[DATA_W-1:0];
    end else begin : g_plain
      assign data_o = voted;
    end
  endgenerate

endmodule

// File: rtl/link_codec.sv
module link_codec
  import link_codec_pkg::*;
#(
  parameter int unsigned DATA_W = 15,
  parameter bit          INV_EN = 1'b1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 in_valid_i,
  output logic                                 in_ready_o,
  input  logic [DATA_W-1:0]                    in_data_i,
  output logic                                 link_valid_o,
  output logic                                 link_frame_o,
  output logic [phit_width(DATA_W, INV_EN)-1:0] link_data_o,
  input  logic                                 link_valid_i,
  input  logic                                 link_frame_i,
  input  logic [phit_width(DATA_W, INV_EN)-1:0] link_data_i,
  output logic                                 out_valid_o,
  input  logic                                 out_ready_i,
  output logic [DATA_W-1:0]                    out_data_o,
  output logic                                 out_corrected_o
);

  localparam int unsigned PAY_W  = pay_width(DATA_W, INV_EN);
  localparam int unsigned PHIT_W = phit_width(DATA_W, INV_EN);
  localparam int unsigned CODE_W = PHIT_W * SER_RATIO;

  // ---- transmit ----
  logic              tx_load;
  logic [PAY_W-1:0]  tx_payload;
  logic [CODE_W-1:0] tx_coded;

  assign tx_load  = in_valid_i && in_ready_o;
  assign tx_coded = {3{tx_payload}};

  lc_bus_coder #(
    .DATA_W (DATA_W),
    .INV_EN (INV_EN)
  ) i_bus_coder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tx_load),
    .data_i    (in_data_i),
    .payload_o (tx_payload)
  );

  lc_serializer #(
    .PHIT_W (PHIT_W)
  ) i_serializer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (in_valid_i),
    .ready_o      (in_ready_o),
    .coded_i      (tx_coded),
    .link_valid_o (link_valid_o),
    .link_frame_o (link_frame_o),
    .link_data_o  (link_data_o)
  );

  // ---- receive ----
  logic              rx_done;
  logic [CODE_W-1:0] rx_word;
  logic [DATA_W-1:0] rx_data;
  logic              rx_corr;

  lc_deserializer #(
    .PHIT_W (PHIT_W)
  ) i_deserializer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .link_valid_i (link_valid_i),
    .link_frame_i (link_frame_i),
    .link_data_i  (link_data_i),
    .done_o       (rx_done),
    .word_o       (rx_word)
  );

  lc_vote_decoder #(
    .DATA_W (DATA_W),
    .INV_EN (INV_EN)
  ) i_vote_decoder (
    .word_i      (rx_word),
    .data_o      (rx_data),
    .corrected_o (rx_corr)
  );

  // the link cannot stall, so a fresh word overwrites an untaken one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o     <= 1'b0;
      out_data_o      <= '0;
      out_corrected_o <= 1'b0;
    end else if (rx_done) begin
      out_valid_o     <= 1'b1;
      out_data_o      <= rx_data;
      out_corrected_o <= rx_corr;
    end else if (out_ready_i) begin
      out_valid_o     <= 1'b0;
    end
  end

endmodule

// File: rtl/link_codec_chk.sv
module link_codec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic link_valid_o,
  input logic link_frame_o,
  input logic link_valid_i,
  input logic out_valid_o,
  input logic out_ready_i
);

  // R4
  accept_starts_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> link_valid_o && link_frame_o);

  // R4
  ready_low_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_frame_o |-> !in_ready_o);

  // R3
  frame_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_frame_o |-> link_valid_o);

  // R3
  frame_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_frame_o |=> link_valid_o && !link_frame_o);

  // R2
  phit_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && !link_frame_o |-> $past(link_valid_o));

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  // R6
  out_after_phit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(link_valid_i));

endmodule

bind link_codec link_codec_chk i_link_codec_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .link_valid_o (link_valid_o),
  .link_frame_o (link_frame_o),
  .link_valid_i (link_valid_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i)
);

// File: tb/test_link_codec.sv
module test_link_codec;

  localparam int DW = 15;
  localparam int PW = 16;
  localparam int CW = 48;
  localparam int PH = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b1;
  logic          drv_sel = 1'b0;
  logic          drv_valid = 1'b0;
  logic          drv_frame = 1'b0;
  logic [PH-1:0] drv_data = '0;

  logic          in_ready, tx_valid, tx_frame, out_valid, out_corr;
  logic [PH-1:0] tx_data;
  logic [DW-1:0] out_data;
  logic          rx_valid, rx_frame;
  logic [PH-1:0] rx_data;

  assign rx_valid = drv_sel ? drv_valid : tx_valid;
  assign rx_frame = drv_sel ? drv_frame : tx_frame;
  assign rx_data  = drv_sel ? drv_data  : tx_data;

  always #4 clk = ~clk;

  link_codec i_link_codec (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .in_valid_i      (in_valid),
    .in_ready_o      (in_ready),
    .in_data_i       (in_data),
    .link_valid_o    (tx_valid),
    .link_frame_o    (tx_frame),
    .link_data_o     (tx_data),
    .link_valid_i    (rx_valid),
    .link_frame_i    (rx_frame),
    .link_data_i     (rx_data),
    .out_valid_o     (out_valid),
    .out_ready_i     (out_ready),
    .out_data_o      (out_data),
    .out_corrected_o (out_corr)
  );

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] prev_sent = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // expected coded word per R2/R5
  function automatic logic [CW-1:0] model_code(input logic [DW-1:0] d, input logic [DW-1:0] prev,
                                               output logic [DW-1:0] sent);
    logic [PW-1:0] p;
    if ($countones(d ^ prev) > DW / 2) p = {1'b1, ~d};
    else p = {1'b0, d};
    sent = p[DW-1:0];
    return {p, p, p};
  endfunction

  function automatic logic [CW-1:0] plain_code(input logic flag, input logic [DW-1:0] d);
    return {flag, d, flag, d, flag, d};
  endfunction

  task automatic send_word(input logic [DW-1:0] d, output logic [CW-1:0] phits,
                           output logic [3:0] fr, output logic [3:0] vl, output logic [3:0] rd,
                           output logic ov, output logic [DW-1:0] od, output logic oc);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      phits[k*PH +: PH] = tx_data;
      fr[k] = tx_frame;
      vl[k] = tx_valid;
      rd[k] = in_ready;
      if (k < 3) @(negedge clk);
    end
    @(negedge clk);
    ov = out_valid;
    od = out_data;
    oc = out_corr;
  endtask

  task automatic raw_send(input logic [CW-1:0] cw, input int first, input int last, input int gap_at);
    drv_sel = 1'b1;
    for (int k = first; k <= last; k++) begin
      if (k == gap_at) begin
        @(negedge clk);
        drv_valid = 1'b0;
        drv_frame = 1'b1;  // frame with valid low must be ignored too
        @(negedge clk);
      end
      @(negedge clk);
      drv_valid = 1'b1;
      drv_frame = (k == 0);
      drv_data  = cw[k*PH +: PH];
    end
    @(negedge clk);
    drv_valid = 1'b0;
    drv_frame = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 1);
    chk(tx_valid == 1'b0 && tx_frame == 1'b0, "R1 link idle", 64'({tx_valid, tx_frame}), 0);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 0);
  endtask

  task automatic t_layout();
    logic [CW-1:0] ph, exp;
    logic [3:0] fr, vl, rd;
    logic ov, oc;
    logic [DW-1:0] od, sent;
    exp = model_code(15'h1234, prev_sent, sent);
    send_word(15'h1234, ph, fr, vl, rd, ov, od, oc);
    prev_sent = sent;
    chk(ph == exp, "R2 phit layout", 64'(ph), 64'(exp));
    chk(vl == 4'hF, "R2 four valid phits", 64'(vl), 64'hF);
    chk(fr == 4'b0001, "R3 frame on phit0 only", 64'(fr), 64'b0001);
    chk(rd == 4'b1000, "R4 ready pattern", 64'(rd), 64'b1000);
    chk(ov == 1'b1 && od == 15'h1234, "R7 loopback data", 64'({ov, od}), 64'({1'b1, 15'h1234}));
    chk(oc == 1'b0, "R8 clean word", 64'(oc), 0);
  endtask

  task automatic t_invert();
    logic [CW-1:0] ph, exp;
    logic [3:0] fr, vl, rd;
    logic ov, oc;
    logic [DW-1:0] od, sent;
    exp = model_code(15'h7FFF, prev_sent, sent);
    send_word(15'h7FFF, ph, fr, vl, rd, ov, od, oc);
    prev_sent = sent;
    chk(ph == exp, "R5 inverted coding", 64'(ph), 64'(exp));
    chk(ph[DW] == 1'b1, "R5 flag set", 64'(ph[DW]), 1);
    chk(od == 15'h7FFF, "R7 uninvert", 64'(od), 64'h7FFF);
    // prev now 0: seven differing bits keep the word plain
    exp = model_code(15'h007F, prev_sent, sent);
    send_word(15'h007F, ph, fr, vl, rd, ov, od, oc);
    prev_sent = sent;
    chk(ph[DW] == 1'b0, "R5 seven bits no flip", 64'(ph[DW]), 0);
    chk(ph == exp, "R5 seven bits coding", 64'(ph), 64'(exp));
    // eight bits differ from 0x007F
    exp = model_code(15'h0080, prev_sent, sent);
    send_word(15'h0080, ph, fr, vl, rd, ov, od, oc);
    prev_sent = sent;
    chk(ph[DW] == 1'b1, "R5 eight bits flip", 64'(ph[DW]), 1);
    chk(ph[DW-1:0] == 15'h7F7F, "R5 eight bits data", 64'(ph[DW-1:0]), 64'h7F7F);
    chk(od == 15'h0080 && oc == 1'b0, "R7 eight bits out", 64'({oc, od}), 64'h0080);
  endtask

  task automatic t_back_to_back();
    logic [CW-1:0] ea, eb;
    logic [DW-1:0] sa, sb;
    ea = model_code(15'h0F0F, prev_sent, sa);
    eb = model_code(15'h3C3C, sa, sb);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 15'h0F0F;
    @(negedge clk);
    in_data  = 15'h3C3C;
    for (int k = 1; k < 4; k++) @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready at phit3", 64'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tx_frame == 1'b1 && tx_data == eb[PH-1:0], "R4 next word starts at once",
        64'({tx_frame, tx_data}), 64'({1'b1, eb[PH-1:0]}));
    chk(out_valid == 1'b1 && out_data == 15'h0F0F, "R6 first word out", 64'(out_data), 64'h0F0F);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 15'h3C3C, "R6 second word out", 64'(out_data), 64'h3C3C);
    prev_sent = sb;
    chk(ea[PH-1:0] != eb[PH-1:0], "R2 distinct phits", 64'(ea[PH-1:0]), 64'(eb[PH-1:0]));
  endtask

  task automatic t_single_err();
    logic [CW-1:0] cw;
    cw = plain_code(1'b0, 15'h2AAA);
    cw[PW + 5] = ~cw[PW + 5];
    raw_send(cw, 0, 3, -1);
    chk(out_valid && out_data == 15'h2AAA, "R7 single error fixed", 64'(out_data), 64'h2AAA);
    chk(out_corr == 1'b1, "R8 single error flagged", 64'(out_corr), 1);
  endtask

  task automatic t_spread_err();
    logic [CW-1:0] cw;
    cw = plain_code(1'b0, 15'h5155);
    cw[0] = ~cw[0];
    cw[PW + 7] = ~cw[PW + 7];
    cw[2*PW + 15] = ~cw[2*PW + 15];
    raw_send(cw, 0, 3, -1);
    chk(out_data == 15'h5155 && out_corr, "R7 errors in three copies", 64'({out_corr, out_data}), 64'({1'b1, 15'h5155}));
  endtask

  task automatic t_double_err();
    logic [CW-1:0] cw;
    cw = plain_code(1'b0, 15'h4001);
    cw[3] = ~cw[3];
    cw[PW + 3] = ~cw[PW + 3];
    raw_send(cw, 0, 3, -1);
    chk(out_data == 15'h4009, "R7 majority wins over one copy", 64'(out_data), 64'h4009);
    chk(out_corr == 1'b1, "R8 disagreement flagged", 64'(out_corr), 1);
  endtask

  task automatic t_flag_vote();
    logic [CW-1:0] cw;
    cw = plain_code(1'b1, 15'h1111);
    cw[DW] = 1'b0;
    raw_send(cw, 0, 3, -1);
    chk(out_data == 15'h6EEE, "R7 voted flag inverts", 64'(out_data), 64'h6EEE);
    chk(out_corr == 1'b1, "R8 flag copy disagreed", 64'(out_corr), 1);
  endtask

  task automatic t_restart();
    bit seen = 0;
    raw_send(plain_code(1'b0, 15'h7777), 0, 1, -1);
    seen = out_valid;
    raw_send(plain_code(1'b0, 15'h0246), 0, 3, -1);
    chk(seen == 1'b0, "R6 partial word not delivered", 64'(seen), 0);
    chk(out_valid && out_data == 15'h0246 && !out_corr, "R6 restart on frame",
        64'({out_valid, out_corr, out_data}), 64'({2'b10, 15'h0246}));
  endtask

  task automatic t_gap();
    raw_send(plain_code(1'b0, 15'h1357), 0, 3, 2);
    chk(out_valid && out_data == 15'h1357, "R10 gap ignored", 64'({out_valid, out_data}), 64'({1'b1, 15'h1357}));
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 taken word clears", 64'(out_valid), 0);
    drv_sel = 1'b0;
  endtask

  task automatic t_hold();
    logic [CW-1:0] ph;
    logic [3:0] fr, vl, rd;
    logic ov, oc;
    logic [DW-1:0] od, sent;
    void'(model_code(15'h0101, prev_sent, sent));
    prev_sent = sent;
    out_ready = 1'b0;
    send_word(15'h0101, ph, fr, vl, rd, ov, od, oc);
    chk(ov && od == 15'h0101, "R9 first word held", 64'(od), 64'h0101);
    void'(model_code(15'h0202, prev_sent, sent));
    prev_sent = sent;
    send_word(15'h0202, ph, fr, vl, rd, ov, od, oc);
    chk(ov && od == 15'h0202, "R9 overwritten by newer word", 64'(od), 64'h0202);
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == 15'h0202, "R9 held while not ready", 64'({out_valid, out_data}), 64'({1'b1, 15'h0202}));
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 cleared after take", 64'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_invert();
    t_back_to_back();
    t_single_err();
    t_spread_err();
    t_double_err();
    t_flag_vote();
    t_restart();
    t_gap();
    t_hold();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule